// File: doc/BRIEF.md
# Scalar Single-Precision Square-Root Unit

This execution unit takes the square root of one IEEE-754 single-precision value and places it in the low 32-bit lane of a 256-bit destination register image. The other lanes of that image come from one of two merge rules, picked per operation by a mode input. In legacy mode the upper lanes of the old destination are kept. In extended mode, lanes 1 to 3 are copied from the first source and the top 128 bits are cleared.

The root is built one bit per cycle by a restoring recurrence. The recurrence yields 24 significand bits, a guard bit and a sticky remainder, and the result is then rounded under a 2-bit rounding mode. Special operands (zeros, infinities, NaNs and negatives) skip the recurrence. The unit reports three exception flags: invalid, inexact and denormal.

A controller sequences each operation through five states:
- ST_IDLE: waits for a start pulse and captures the operands.
- ST_CLASSIFY: sorts the operand. It goes to ST_FINISH for special operands and to ST_ITER otherwise, loading the root core on the way.
- ST_ITER: runs 25 recurrence steps, then goes to ST_ROUND.
- ST_ROUND: rounds the root, then goes to ST_FINISH.
- ST_FINISH: raises done for one cycle, then returns to ST_IDLE.

Top module: `sqrt_lane_unit`

## Requirements
- R1: For a positive normal operand under round-to-nearest-even, result[31:0] is the correctly rounded single-precision square root of src2_i.
- R2: rmode_i selects the rounding: 2'b00 nearest-even, 2'b01 toward zero, 2'b10 toward +infinity, 2'b11 toward -infinity. A round-up that carries out of the significand increments the exponent.
- R3: flags_o[1] (inexact) is 1 exactly when the rounded root differs from the true root.
- R4: With mode_i = 0 (legacy), result[255:32] equals old_dst_i captured at start.
- R5: With mode_i = 1 (extended), result[127:32] equals src1_i captured at start, and result[255:128] is zero.
- R6: A negative nonzero operand, including -infinity and negative subnormals, gives 32'hFFC00000 and sets flags_o[0] (invalid).
- R7: A signalling NaN (exponent all ones, bit 22 clear, fraction nonzero) returns the operand with bit 22 set and sets invalid. A quiet NaN returns unchanged with no flag.
- R8: +0, -0 and +infinity return themselves with all flags clear.
- R9: A subnormal operand sets flags_o[2] (denormal). Its positive root is computed exactly as for normal operands, and no result is ever subnormal.
- R10: done_o is high for exactly one cycle per operation. result_o and flags_o change only on the cycle done_o rises, and otherwise hold.
- R11: A start pulse while an operation is in progress is ignored: it neither changes that result nor produces an extra done.
- R12: After reset, done_o, result_o and flags_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse, taken only in ST_IDLE |
| mode_i | input | 1 | Merge mode: 0 legacy, 1 extended |
| old_dst_i | input | 224 | Old destination bits [255:32] |
| src1_i | input | 96 | First source bits [127:32] |
| src2_i | input | 32 | Single-precision operand |
| rmode_i | input | 2 | Rounding mode |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 256 | Merged destination image |
| flags_o | output | 3 | {denormal, inexact, invalid} |

## Verification
Two situations are hardest to reach from the ports. The first is a rounding increment that carries out of an all-ones significand into the exponent. It happens only for operands just below a power of four under a directed rounding mode, so the stimulus uses 0x407FFFFF with rounding toward +infinity. The second is a start pulse that arrives in mid-recurrence. The bench pulses start a few cycles into an operation with a different operand and mode, then confirms that the first result comes back with a single done.

// File: rtl/sqrt_pkg.sv
package sqrt_pkg;
    localparam int EXP_W    = 8;
    localparam int MAN_W    = 23;
    localparam int FP_W     = EXP_W + MAN_W + 1;
    localparam int EXP_BIAS = 127;
    localparam int ROOT_W   = MAN_W + 2;
    localparam int RAD_W    = 2 * ROOT_W;
    localparam logic [FP_W-1:0] QNAN_DEFAULT = 32'hFFC0_0000;

    typedef enum logic [2:0] {
        ST_IDLE, ST_CLASSIFY, ST_ITER, ST_ROUND, ST_FINISH
    } state_t;

    typedef enum logic [1:0] {
        RM_NEAR = 2'b00, RM_ZERO = 2'b01, RM_UP = 2'b10, RM_DOWN = 2'b11
    } rmode_t;
endpackage

// File: rtl/sqrt_classify.sv
module sqrt_classify
    import sqrt_pkg::*;
(
    input  logic [FP_W-1:0]  op_i,
    output logic             special_o,
    output logic [FP_W-1:0]  special_val_o,
    output logic             invalid_o,
    output logic             denorm_o,
    output logic [RAD_W-1:0] radicand_o,
    output logic [EXP_W-1:0] res_exp_o
);
    localparam logic signed [9:0] SUB_OFF = 10'(EXP_BIAS + MAN_W - 1);
    localparam logic signed [9:0] BIAS10  = 10'(EXP_BIAS);

    logic              sgn;
    logic [EXP_W-1:0]  ex;
    logic [MAN_W-1:0]  fr;
    logic [4:0]        msb;
    logic [MAN_W:0]    sig;
    logic [ROOT_W-1:0] sig_x;
    logic signed [9:0] unb, unb_e;

    always_comb begin
        sgn = op_i[FP_W-1];
        ex  = op_i[FP_W-2:MAN_W];
        fr  = op_i[MAN_W-1:0];
        msb = '0;
        for (int i = 0; i < MAN_W; i++)
            if (fr[i]) msb = 5'(i);

        denorm_o      = (ex == '0) && (fr != '0);
        special_o     = 1'b0;
        special_val_o = op_i;
        invalid_o     = 1'b0;
        if (ex == '1 && fr != '0) begin
            special_o     = 1'b1;
            special_val_o = {op_i[FP_W-1:MAN_W], 1'b1, op_i[MAN_W-2:0]};
            invalid_o     = ~fr[MAN_W-1];
        end else if (ex == '0 && fr == '0) begin
            special_o = 1'b1;
        end else if (sgn) begin
            special_o     = 1'b1;
            special_val_o = QNAN_DEFAULT;
            invalid_o     = 1'b1;
        end else if (ex == '1) begin
            special_o = 1'b1;
        end

        if (ex == '0) begin
            sig = {1'b0, fr} << (5'(MAN_W) - msb);
            unb = $signed({5'b0, msb}) - SUB_OFF;
        end else begin
            sig = {1'b1, fr};
            unb = $signed({2'b0, ex}) - BIAS10;
        end
        if (unb[0]) begin
            sig_x = {sig, 1'b0};
            unb_e = unb - 10'sd1;
        end else begin
            sig_x = {1'b0, sig};
            unb_e = unb;
        end
        radicand_o = {sig_x, {ROOT_W{1'b0}}};
        res_exp_o  = EXP_W'((unb_e + (BIAS10 <<< 1)) >>> 1);
    end
endmodule

// File: rtl/sqrt_root_core.sv
module sqrt_root_core #(
    parameter int ROOT_W = 25
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load_i,
    input  logic                  step_i,
    input  logic [2*ROOT_W-1:0]   rad_i,
    output logic [ROOT_W-1:0]     root_o,
    output logic                  rem_nz_o
);
    localparam int RAD_W = 2 * ROOT_W;
    localparam int RW    = ROOT_W + 3;

    logic [RAD_W-1:0]  rad_q;
    logic [RW-1:0]     rem_q, rem_sh, trial;
    logic [ROOT_W-1:0] root_q;
    logic              ge;

    always_comb begin
        rem_sh = {rem_q[RW-3:0], rad_q[RAD_W-1 -: 2]};
        trial  = {1'b0, root_q, 2'b01};
        ge     = (rem_sh >= trial);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rad_q  <= '0;
            rem_q  <= '0;
            root_q <= '0;
        end else if (load_i) begin
            rad_q  <= rad_i;
            rem_q  <= '0;
            root_q <= '0;
        end else if (step_i) begin
            rad_q  <= rad_q << 2;
            rem_q  <= ge ? (rem_sh - trial) : rem_sh;
            root_q <= {root_q[ROOT_W-2:0], ge};
        end
    end

    assign root_o   = root_q;
    assign rem_nz_o = |rem_q;
endmodule

// File: rtl/sqrt_rounder.sv
module sqrt_rounder
    import sqrt_pkg::*;
(
    input  logic [ROOT_W-1:0] q_i,
    input  logic              sticky_i,
    input  logic [EXP_W-1:0]  exp_i,
    input  rmode_t            rm_i,
    output logic [FP_W-1:0]   result_o,
    output logic              inexact_o
);
    logic [MAN_W:0] mant;
    logic           guard, inc, carry;

    always_comb begin
        mant  = q_i[ROOT_W-1:1];
        guard = q_i[0];
        unique case (rm_i)
            RM_NEAR: inc = guard & (sticky_i | mant[0]);
            RM_UP:   inc = guard | sticky_i;
            default: inc = 1'b0;
        endcase
        carry     = (&mant) & inc;
        result_o  = {1'b0, exp_i + EXP_W'(carry), mant[MAN_W-1:0] + MAN_W'(inc)};
        inexact_o = guard | sticky_i;
    end
endmodule

// File: rtl/sqrt_lane_unit.sv
module sqrt_lane_unit
    import sqrt_pkg::*;
#(
    parameter int REG_W  = 256,
    parameter int VEC_W  = 128,
    parameter int LANE_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic                    mode_i,
    input  logic [REG_W-1:LANE_W]   old_dst_i,
    input  logic [VEC_W-1:LANE_W]   src1_i,
    input  logic [LANE_W-1:0]       src2_i,
    input  logic [1:0]              rmode_i,
    output logic                    done_o,
    output logic [REG_W-1:0]        result_o,
    output logic [2:0]              flags_o
);
    localparam int UP_W   = REG_W - LANE_W;
    localparam int ZERO_W = REG_W - VEC_W;
    localparam int CNT_W  = $clog2(ROOT_W);

    state_t             state, nxt;
    logic [LANE_W-1:0]  op_q;
    rmode_t             rm_q;
    logic               mode_q;
    logic [UP_W-1:0]    upper_q, upper_merged;
    logic [EXP_W-1:0]   exp_q;
    logic               den_q;
    logic [CNT_W-1:0]   cnt;

    logic               is_special, c_invalid, c_denorm;
    logic [FP_W-1:0]    special_val, rnd_val;
    logic [RAD_W-1:0]   radicand;
    logic [EXP_W-1:0]   c_exp;
    logic [ROOT_W-1:0]  root;
    logic               rem_nz, r_inexact;

    generate
        if (ZERO_W > 0) begin : g_zero_top
            assign upper_merged = mode_i ? {{ZERO_W{1'b0}}, src1_i} : old_dst_i;
        end else begin : g_no_top
            assign upper_merged = mode_i ? src1_i : old_dst_i;
        end
    endgenerate

    sqrt_classify u_class (
        .op_i(op_q), .special_o(is_special), .special_val_o(special_val),
        .invalid_o(c_invalid), .denorm_o(c_denorm),
        .radicand_o(radicand), .res_exp_o(c_exp)
    );

    sqrt_root_core #(.ROOT_W(ROOT_W)) u_core (
        .clk(clk), .rst_n(rst_n),
        .load_i(state == ST_CLASSIFY), .step_i(state == ST_ITER),
        .rad_i(radicand), .root_o(root), .rem_nz_o(rem_nz)
    );

    sqrt_rounder u_round (
        .q_i(root), .sticky_i(rem_nz), .exp_i(exp_q), .rm_i(rm_q),
        .result_o(rnd_val), .inexact_o(r_inexact)
    );

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:     if (start_i) nxt = ST_CLASSIFY;
            ST_CLASSIFY: nxt = is_special ? ST_FINISH : ST_ITER;
            ST_ITER:     if (cnt == CNT_W'(ROOT_W - 1)) nxt = ST_ROUND;
            ST_ROUND:    nxt = ST_FINISH;
            ST_FINISH:   nxt = ST_IDLE;
            default:     nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o   <= 1'b0;
            result_o <= '0;
            flags_o  <= '0;
            op_q     <= '0;
            rm_q     <= RM_NEAR;
            mode_q   <= 1'b0;
            upper_q  <= '0;
            exp_q    <= '0;
            den_q    <= 1'b0;
            cnt      <= '0;
        end else begin
            done_o <= (nxt == ST_FINISH);
            unique case (state)
                ST_IDLE: if (start_i) begin
                    op_q    <= src2_i;
                    rm_q    <= rmode_t'(rmode_i);
                    mode_q  <= mode_i;
                    upper_q <= upper_merged;
                end
                ST_CLASSIFY: begin
                    cnt   <= '0;
                    exp_q <= c_exp;
                    den_q <= c_denorm;
                    if (is_special) begin
                        result_o <= {upper_q, special_val};
                        flags_o  <= {c_denorm, 1'b0, c_invalid};
                    end
                end
                ST_ITER:  cnt <= cnt + 1'b1;
                ST_ROUND: begin
                    result_o <= {upper_q, rnd_val};
                    flags_o  <= {den_q, r_inexact, 1'b0};
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/sqrt_lane_chk.sv
module sqrt_lane_chk #(
    parameter int REG_W = 256,
    parameter int VEC_W = 128
) (
    input logic             clk,
    input logic             rst_n,
    input logic             done_o,
    input logic [REG_W-1:0] result_o,
    input logic [2:0]       flags_o,
    input logic             mode_q
);
    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R10
    hold_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(result_o) && $stable(flags_o)));

    // R5
    ext_top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && mode_q) |-> (result_o[REG_W-1:VEC_W] == '0));

    // R6
    invalid_gives_nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && flags_o[0]) |-> (result_o[30:23] == 8'hFF && result_o[22]));

    // R9
    never_subnormal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !(result_o[30:23] == 8'h00 && result_o[22:0] != '0));
endmodule

bind sqrt_lane_unit sqrt_lane_chk #(.REG_W(REG_W), .VEC_W(VEC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .done_o(done_o),
    .result_o(result_o), .flags_o(flags_o), .mode_q(mode_q)
);

// File: tb/sim_sqrt_lane_unit.sv
`timescale 1ns/1ps
module sim_sqrt_lane_unit;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         mode = 1'b0;
    logic [255:32] old_dst = '0;
    logic [127:32] src1 = '0;
    logic [31:0]  src2 = '0;
    logic [1:0]   rmode = 2'b00;
    logic         done;
    logic [255:0] result;
    logic [2:0]   flags;

    int total = 0;
    int bad = 0;
    logic [255:0] got_res;
    logic [2:0]   got_flags;

    always #2.5 clk = ~clk;

    sqrt_lane_unit u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .mode_i(mode),
        .old_dst_i(old_dst), .src1_i(src1), .src2_i(src2), .rmode_i(rmode),
        .done_o(done), .result_o(result), .flags_o(flags)
    );

    task automatic chk(input string req, input logic [255:0] got, input logic [255:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    // independent model for positive finite nonzero operands
    function automatic logic [31:0] ref_sqrt(input logic [31:0] x, input logic [1:0] rm,
                                             output logic inx);
        longint unsigned m, r, q, t, mant;
        int e;
        logic g, s, inc;
        if (x[30:23] == 0) begin
            m = {41'd0, x[22:0]};
            e = -126;
            while (m[23] == 1'b0) begin m = m << 1; e = e - 1; end
        end else begin
            m = {40'd0, 1'b1, x[22:0]};
            e = int'(x[30:23]) - 127;
        end
        if (e % 2 != 0) begin m = m << 1; e = e - 1; end
        r = m << 25;
        q = 0;
        for (int b = 25; b >= 0; b--) begin
            t = q | (64'd1 << b);
            if (t * t <= r) q = t;
        end
        g = q[0];
        s = (r - q * q) != 0;
        mant = q >> 1;
        case (rm)
            2'b00: inc = g & (s | mant[0]);
            2'b10: inc = g | s;
            default: inc = 1'b0;
        endcase
        mant = mant + inc;
        e = e / 2 + 127;
        if (mant == 64'd1 << 24) begin mant = 64'd1 << 23; e = e + 1; end
        inx = g | s;
        return {1'b0, e[7:0], mant[22:0]};
    endfunction

    task automatic run_op(input logic md, input logic [255:32] od, input logic [127:32] s1,
                          input logic [31:0] x, input logic [1:0] rm);
        logic seen;
        seen = 1'b0;
        @(negedge clk);
        mode = md; old_dst = od; src1 = s1; src2 = x; rmode = rm; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            if (done) begin seen = 1'b1; break; end
        end
        chk("R10 done seen", {255'd0, seen}, 256'd1);
        got_res = result;
        got_flags = flags;
    endtask

    task automatic lo_chk(input string req, input logic [31:0] x, input logic [1:0] rm,
                          input logic [31:0] exp_v, input logic [2:0] exp_f);
        run_op(1'b0, '0, '0, x, rm);
        chk(req, {221'd0, got_flags, got_res[31:0]}, {221'd0, exp_f, exp_v});
    endtask

    task automatic model_chk(input string req, input logic [31:0] x, input logic [1:0] rm);
        logic inx;
        logic [31:0] ev;
        ev = ref_sqrt(x, rm, inx);
        lo_chk(req, x, rm, ev, {(x[30:23] == 0), inx, 1'b0});
    endtask

    task automatic t_reset;
        chk("R12 reset state", {250'd0, done, flags} | result, 256'd0);
    endtask

    task automatic t_normals;
        lo_chk("R1 R3 sqrt 4.0 exact", 32'h4080_0000, 2'b00, 32'h4000_0000, 3'b000);
        lo_chk("R1 R3 sqrt 2.0 inexact", 32'h4000_0000, 2'b00, 32'h3FB5_04F3, 3'b010);
        model_chk("R1 sqrt 1.0", 32'h3F80_0000, 2'b00);
        model_chk("R1 sqrt 3.0", 32'h4040_0000, 2'b00);
        model_chk("R1 sqrt max normal", 32'h7F7F_FFFF, 2'b00);
        model_chk("R1 sqrt min normal", 32'h0080_0000, 2'b00);
        model_chk("R1 sqrt pattern", 32'h1234_5678, 2'b00);
        model_chk("R3 sqrt 0.25", 32'h3E80_0000, 2'b00);
    endtask

    task automatic t_rounding;
        lo_chk("R2 2.0 toward zero", 32'h4000_0000, 2'b01, 32'h3FB5_04F3, 3'b010);
        lo_chk("R2 2.0 toward +inf", 32'h4000_0000, 2'b10, 32'h3FB5_04F4, 3'b010);
        lo_chk("R2 2.0 toward -inf", 32'h4000_0000, 2'b11, 32'h3FB5_04F3, 3'b010);
        lo_chk("R2 near-four nearest", 32'h407F_FFFF, 2'b00, 32'h3FFF_FFFF, 3'b010);
        lo_chk("R2 near-four carry into exponent", 32'h407F_FFFF, 2'b10, 32'h4000_0000, 3'b010);
        for (int m = 0; m < 4; m++) model_chk("R2 sqrt 3.0 each mode", 32'h4040_0000, 2'(m));
        model_chk("R2 pattern toward +inf", 32'h5A5A_1234, 2'b10);
    endtask

    task automatic t_merge;
        logic [255:32] od;
        logic [127:32] s1;
        od = {7{32'hA5C3_0F96}};
        s1 = {3{32'h1357_9BDF}};
        run_op(1'b0, od, s1, 32'h4080_0000, 2'b00);
        chk("R4 legacy keeps upper lanes", got_res, {od, 32'h4000_0000});
        run_op(1'b1, od, s1, 32'h4080_0000, 2'b00);
        chk("R5 extended copies src1 and clears top", got_res, {128'd0, s1, 32'h4000_0000});
    endtask

    task automatic t_specials;
        lo_chk("R6 negative one", 32'hBF80_0000, 2'b00, 32'hFFC0_0000, 3'b001);
        lo_chk("R6 negative infinity", 32'hFF80_0000, 2'b00, 32'hFFC0_0000, 3'b001);
        lo_chk("R6 negative subnormal", 32'h8000_0001, 2'b00, 32'hFFC0_0000, 3'b101);
        lo_chk("R7 signalling NaN quieted", 32'h7FA0_0000, 2'b00, 32'h7FE0_0000, 3'b001);
        lo_chk("R7 quiet NaN passes", 32'hFFC1_2345, 2'b00, 32'hFFC1_2345, 3'b000);
        lo_chk("R8 plus zero", 32'h0000_0000, 2'b10, 32'h0000_0000, 3'b000);
        lo_chk("R8 minus zero", 32'h8000_0000, 2'b11, 32'h8000_0000, 3'b000);
        lo_chk("R8 plus infinity", 32'h7F80_0000, 2'b00, 32'h7F80_0000, 3'b000);
    endtask

    task automatic t_subnormal;
        lo_chk("R9 smallest subnormal", 32'h0000_0001, 2'b00, 32'h1A35_04F3, 3'b110);
        model_chk("R9 largest subnormal", 32'h007F_FFFF, 2'b00);
        model_chk("R9 mid subnormal toward zero", 32'h0001_2345, 2'b01);
    endtask

    task automatic t_hold;
        logic [255:0] keep;
        logic [2:0]   keepf;
        run_op(1'b0, {7{32'h0F0F_0F0F}}, '0, 32'h4110_0000, 2'b00);
        keep = got_res;
        keepf = got_flags;
        chk("R1 sqrt 9.0", {224'd0, keep[31:0]}, {224'd0, 32'h4040_0000});
        @(negedge clk);
        chk("R10 done drops after one cycle", {255'd0, done}, 256'd0);
        src2 = 32'h4000_0000; mode = 1'b1; old_dst = '1;
        repeat (10) @(negedge clk);
        chk("R10 outputs held", result ^ {253'd0, flags ^ keepf}, keep);
    endtask

    task automatic t_busy;
        int dones;
        logic [255:32] od;
        od = {7{32'h5555_AAAA}};
        dones = 0;
        @(negedge clk);
        mode = 1'b0; old_dst = od; src2 = 32'h4080_0000; rmode = 2'b00; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        mode = 1'b1; src1 = '1; src2 = 32'h4110_0000; rmode = 2'b10; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            if (done) begin
                dones++;
                if (dones == 1) got_res = result;
            end
        end
        chk("R11 busy start ignored result", got_res, {od, 32'h4000_0000});
        chk("R11 single done", 256'(dones), 256'd1);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_normals();
        t_rounding();
        t_merge();
        t_specials();
        t_subnormal();
        t_hold();
        t_busy();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        total++;
        bad++;
        $display("FAIL watchdog run did not finish got=hung exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule